// File: doc/BRIEF.md
# Configuration image header parser

This block watches the opening bytes of a configuration image, delivered one byte per cycle over a valid/ready stream. It stores the bytes in a small buffer addressed by their offset in the image. It then reads the buffer in whatever order the parse needs, and it asks for more input only when the byte it wants next has not arrived. From the header it finds the offset where the payload begins. It also finds an array of packed component sizes, unpacks the sizes and sums them into a payload length in bytes. Each image ends with a one-cycle `done` strobe. On that strobe the results are presented, or `err` is raised when the header is malformed.

The parse is run by one state machine. `S_HLEN` fetches the header length and goes to `S_NREC`, or to `S_ERR` if the length is zero. `S_NREC` fetches the record count and goes to `S_RID`, or to `S_ERR` if the count is zero. `S_RID` reads a record identifier and goes to `S_ROFF`. `S_ROFF` gathers the four offset bytes and then goes to `S_RCHK`. `S_RCHK` decides what happens next: it goes to `S_CNT0` once both wanted records are held, back to `S_RID` for the next record, or to `S_ERR` when the table is exhausted. `S_CNT0` and `S_CNT1` read the component count. From there the machine goes to `S_DONE` when the count is zero, or else to `S_SZ`. `S_SZ` collects the bytes of one packed size and goes to `S_ACC`. `S_ACC` adds the scaled size and goes back to `S_SZ`, or on to `S_DONE` after the last component, or to `S_ERR` on overflow. From any reading state, an offset beyond the buffer leads to `S_ERR`. Both `S_DONE` and `S_ERR` return to `S_HLEN` for the next image.

Top module: `cfg_hdr_parser`

## Requirements
- R1: The header length is the byte at image offset 24. A header length of zero ends the image with `err`.
- R2: The record count is the byte at offset (header length - 1). Records are 9 bytes long and start at offset header length. In each record, byte 0 is an identifier and bytes 1..4 hold a little-endian 32-bit offset.
- R3: Identifier 8 supplies the payload start offset and identifier 5 supplies the size-array offset. A later record with the same identifier replaces the earlier value, and all other identifiers are skipped. Scanning stops with the record at which both values are held, so later records are never requested.
- R4: A held offset of zero counts as absent. If either value is absent after the last record, or the record count is zero, the image ends with `err`.
- R5: The component count is a little-endian 16-bit value at offsets 55 (low) and 56 (high). A count of zero gives `pay_bytes` = 0 without `err`.
- R6: Component i occupies bits 22*i to 22*i+21 of the size array, with bit b of the array being bit (b mod 8) of array byte b/8. Only bytes that hold bits of a field are requested.
- R7: `pay_bytes` is 16 times the sum of all component sizes, and `pay_start` is the payload start offset.
- R8: If the 32-bit payload byte total would exceed 2^32-1, the image ends with `err`.
- R9: A needed byte at offset BUF_BYTES (512) or above is never requested. Needing one ends the image with `err`.
- R10: `in_ready` is high only while the parser is waiting for a byte it has not yet received. Per image, exactly (highest offset read + 1) bytes are accepted.
- R11: `done` is a one-cycle pulse. `err` is high only with `done`. On `err`, `pay_start` and `pay_bytes` read 0. Both hold their value between pulses.
- R12: After reset `done`, `err` and both results are 0 and `in_ready` is 1. In the `done` cycle the buffer is empty and the next accepted byte is offset 0 of a new image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Image byte present on `in_data` |
| in_data | input | 8 | Image byte, offsets in arrival order from 0 |
| in_ready | output | 1 | Parser takes the byte this cycle when `in_valid` is high |
| done | output | 1 | One-cycle end-of-image strobe |
| err | output | 1 | Header malformed, qualified by `done` |
| pay_start | output | 32 | Payload start offset |
| pay_bytes | output | 32 | Payload length in bytes |

## Verification
`in_ready` depends only on registered state, so a byte offered at a falling edge is taken at the next rising edge exactly when `in_ready` was high at that falling edge. `done`, `err`, `pay_start` and `pay_bytes` are registered from the terminal state and appear together one cycle after it. That is at least one cycle after the last accepted byte, with the exact gap depending on how many buffered reads remain. The bench therefore samples at every falling edge, counts the bytes it has seen accepted, and reads all results in the first falling edge where `done` is high. It compares them against a bit-by-bit model of the header walk that also predicts the number of bytes that should have been consumed.

// File: rtl/chp_pkg.sv
package chp_pkg;

    typedef enum logic [3:0] {
        S_HLEN,
        S_NREC,
        S_RID,
        S_ROFF,
        S_RCHK,
        S_CNT0,
        S_CNT1,
        S_SZ,
        S_ACC,
        S_DONE,
        S_ERR
    } chp_state_e;

    // States in which a buffered image byte is consumed.
    function automatic logic reads_byte(chp_state_e s);
        return (s == S_HLEN) || (s == S_NREC) || (s == S_RID) || (s == S_ROFF) ||
               (s == S_CNT0) || (s == S_CNT1) || (s == S_SZ);
    endfunction

endpackage

// File: rtl/chp_byte_store.sv
module chp_byte_store #(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          clr,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic [AW:0]   fill
);

    logic [7:0] mem [DEPTH];

    // Bytes land at the offset equal to how many have arrived so far.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[fill[AW-1:0]] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill <= '0;
        end else if (clr) begin
            fill <= '0;
        end else if (wr_en) begin
            fill <= fill + 1'b1;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/chp_size_unpack.sv
module chp_size_unpack #(
    parameter int SIZE_BITS   = 22,
    parameter int FRAME_SHIFT = 4,
    parameter int ACC_W       = 32,
    parameter int WIN_W       = 32
) (
    input  logic [WIN_W-1:0] win,
    input  logic [2:0]       bit_ofs,
    input  logic [ACC_W-1:0] acc,
    output logic [ACC_W-1:0] sum,
    output logic             ovf
);

    logic [SIZE_BITS-1:0] field;
    logic [ACC_W:0]       wide;

    // Align the gathered bytes so the field starts at bit 0, then scale by the frame size.
    always_comb begin
        field = SIZE_BITS'(win >> bit_ofs);
        wide  = {1'b0, acc} + ((ACC_W + 1)'(field) << FRAME_SHIFT);
        sum   = wide[ACC_W-1:0];
        ovf   = wide[ACC_W];
    end

endmodule

// File: rtl/cfg_hdr_parser.sv
module cfg_hdr_parser
    import chp_pkg::*;
#(
    parameter int BUF_BYTES   = 512,
    parameter int HLEN_OFS    = 24,
    parameter int CNT_OFS     = 55,
    parameter int REC_BYTES   = 9,
    parameter int ID_PAYLOAD  = 8,
    parameter int ID_SIZES    = 5,
    parameter int SIZE_BITS   = 22,
    parameter int FRAME_BYTES = 16,
    parameter int ACC_W       = 32,
    parameter int OFS_W       = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             done,
    output logic             err,
    output logic [OFS_W-1:0] pay_start,
    output logic [ACC_W-1:0] pay_bytes
);

    localparam int AW          = $clog2(BUF_BYTES);
    localparam int FRAME_SHIFT = $clog2(FRAME_BYTES);
    localparam int OFS_BYTES   = OFS_W / 8;
    localparam int WIN_BYTES   = (SIZE_BITS + 14) / 8;
    localparam int WIN_W       = 8 * WIN_BYTES;
    localparam int XW          = OFS_W + 8;

    chp_state_e state, nxt;

    logic [7:0]       hlen, nrec, rec_idx, rec_id;
    logic [XW-1:0]    rec_base;
    logic [2:0]       kk;
    logic [OFS_W-1:0] rec_ofs, pstart, astart;
    logic             got_p, got_a;
    logic [15:0]      ccount, cidx;
    logic [31:0]      bitpos;
    logic [WIN_W-1:0] win;
    logic [ACC_W-1:0] acc;

    logic [XW-1:0]    want;
    logic [7:0]       rd_data;
    logic [AW:0]      fill;
    logic             rd_state, in_range, have, bad_addr;
    logic [2:0]       last_k;
    logic             hit_p, hit_a, p_next, a_next;
    logic [ACC_W-1:0] sum;
    logic             ovf;

    // ---------------- buffer and unpacker ----------------
    chp_byte_store #(.DEPTH(BUF_BYTES), .AW(AW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (in_valid && in_ready),
        .wr_data (in_data),
        .clr     ((state == S_DONE) || (state == S_ERR)),
        .rd_addr (want[AW-1:0]),
        .rd_data (rd_data),
        .fill    (fill)
    );

    chp_size_unpack #(
        .SIZE_BITS   (SIZE_BITS),
        .FRAME_SHIFT (FRAME_SHIFT),
        .ACC_W       (ACC_W),
        .WIN_W       (WIN_W)
    ) u_unpack (
        .win     (win),
        .bit_ofs (bitpos[2:0]),
        .acc     (acc),
        .sum     (sum),
        .ovf     (ovf)
    );

    // ---------------- offset wanted in the current state ----------------
    always_comb begin
        unique case (state)
            S_HLEN:  want = XW'(HLEN_OFS);
            S_NREC:  want = XW'(hlen) - XW'(1);
            S_RID:   want = rec_base;
            S_ROFF:  want = rec_base + XW'(1) + XW'(kk);
            S_CNT0:  want = XW'(CNT_OFS);
            S_CNT1:  want = XW'(CNT_OFS + 1);
            S_SZ:    want = XW'(astart) + XW'(bitpos >> 3) + XW'(kk);
            default: want = '0;
        endcase
    end

    always_comb begin
        rd_state = reads_byte(state);
        in_range = want < XW'(BUF_BYTES);
        have     = rd_state && in_range && (want < XW'(fill));
        bad_addr = rd_state && !in_range;
        in_ready = rd_state && in_range && !have;
        last_k   = 3'((32'(bitpos[2:0]) + 32'(SIZE_BITS - 1)) >> 3);
        hit_p    = (rec_id == 8'(ID_PAYLOAD));
        hit_a    = (rec_id == 8'(ID_SIZES));
        p_next   = hit_p ? (rec_ofs != '0) : got_p;
        a_next   = hit_a ? (rec_ofs != '0) : got_a;
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_HLEN;
        end else begin
            state <= nxt;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        nxt = state;
        unique case (state)
            S_HLEN: if (have) nxt = (rd_data == 8'd0) ? S_ERR : S_NREC;
            S_NREC: if (have) nxt = (rd_data == 8'd0) ? S_ERR : S_RID;
            S_RID:  if (have) nxt = S_ROFF;
            S_ROFF: if (have && (kk == 3'(OFS_BYTES - 1))) nxt = S_RCHK;
            S_RCHK: begin
                if (p_next && a_next)               nxt = S_CNT0;
                else if (rec_idx == nrec - 8'd1)    nxt = S_ERR;
                else                                nxt = S_RID;
            end
            S_CNT0: if (have) nxt = S_CNT1;
            S_CNT1: if (have) nxt = ({rd_data, ccount[7:0]} == 16'd0) ? S_DONE : S_SZ;
            S_SZ:   if (have && (kk == last_k)) nxt = S_ACC;
            S_ACC: begin
                if (ovf)                              nxt = S_ERR;
                else if (cidx == ccount - 16'd1)      nxt = S_DONE;
                else                                  nxt = S_SZ;
            end
            S_DONE: nxt = S_HLEN;
            S_ERR:  nxt = S_HLEN;
        endcase
        if (bad_addr) begin
            nxt = S_ERR;
        end
    end

    // ---------------- parse datapath ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hlen     <= '0;
            nrec     <= '0;
            rec_idx  <= '0;
            rec_id   <= '0;
            rec_base <= '0;
            kk       <= '0;
            rec_ofs  <= '0;
            pstart   <= '0;
            astart   <= '0;
            got_p    <= 1'b0;
            got_a    <= 1'b0;
            ccount   <= '0;
            cidx     <= '0;
            bitpos   <= '0;
            win      <= '0;
            acc      <= '0;
        end else begin
            unique case (state)
                S_HLEN: if (have) hlen <= rd_data;
                S_NREC: if (have) begin
                    nrec     <= rd_data;
                    rec_base <= XW'(hlen);
                    rec_idx  <= '0;
                end
                S_RID: if (have) begin
                    rec_id <= rd_data;
                    kk     <= '0;
                end
                S_ROFF: if (have) begin
                    rec_ofs[8*int'(kk) +: 8] <= rd_data;
                    kk <= kk + 3'd1;
                end
                S_RCHK: begin
                    if (hit_p) begin
                        pstart <= rec_ofs;
                        got_p  <= (rec_ofs != '0);
                    end
                    if (hit_a) begin
                        astart <= rec_ofs;
                        got_a  <= (rec_ofs != '0);
                    end
                    rec_idx  <= rec_idx + 8'd1;
                    rec_base <= rec_base + XW'(REC_BYTES);
                end
                S_CNT0: if (have) ccount[7:0] <= rd_data;
                S_CNT1: if (have) begin
                    ccount[15:8] <= rd_data;
                    cidx   <= '0;
                    bitpos <= '0;
                    kk     <= '0;
                    win    <= '0;
                    acc    <= '0;
                end
                S_SZ: if (have) begin
                    win[8*int'(kk) +: 8] <= rd_data;
                    kk <= kk + 3'd1;
                end
                S_ACC: begin
                    acc    <= sum;
                    cidx   <= cidx + 16'd1;
                    bitpos <= bitpos + 32'(SIZE_BITS);
                    kk     <= '0;
                    win    <= '0;
                end
                S_DONE, S_ERR: begin
                    got_p  <= 1'b0;
                    got_a  <= 1'b0;
                    pstart <= '0;
                    astart <= '0;
                    acc    <= '0;
                    ccount <= '0;
                end
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            err       <= 1'b0;
            pay_start <= '0;
            pay_bytes <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            if (state == S_DONE) begin
                done      <= 1'b1;
                pay_start <= pstart;
                pay_bytes <= acc;
            end else if (state == S_ERR) begin
                done      <= 1'b1;
                err       <= 1'b1;
                pay_start <= '0;
                pay_bytes <= '0;
            end
        end
    end

endmodule

// File: rtl/chp_checker.sv
module chp_checker #(
    parameter int BUF_BYTES = 512,
    parameter int AW        = $clog2(BUF_BYTES),
    parameter int OFS_W     = 32,
    parameter int ACC_W     = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             done,
    input logic             err,
    input logic [OFS_W-1:0] pay_start,
    input logic [ACC_W-1:0] pay_bytes,
    input logic [AW:0]      fill
);

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_err_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    p_err_zero_results_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (pay_start == '0 && pay_bytes == '0));

    p_hold_results_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(pay_start) && $stable(pay_bytes)));

    p_ready_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (32'(fill) < 32'(BUF_BYTES)));

    p_fresh_image_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fill == '0 && in_ready));

endmodule

bind cfg_hdr_parser chp_checker #(
    .BUF_BYTES (BUF_BYTES),
    .OFS_W     (OFS_W),
    .ACC_W     (ACC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .done      (done),
    .err       (err),
    .pay_start (pay_start),
    .pay_bytes (pay_bytes),
    .fill      (fill)
);

// File: tb/sim_cfg_hdr_parser.sv
module sim_cfg_hdr_parser;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'd0;
    logic        in_ready, done, err;
    logic [31:0] pay_start, pay_bytes;

    always #5 clk = ~clk;

    cfg_hdr_parser u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .done(done), .err(err),
        .pay_start(pay_start), .pay_bytes(pay_bytes)
    );

    int checks = 0;
    int errors = 0;
    int maxoff;
    bit oor;
    logic [7:0] img [0:2047];

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    function automatic int rdm(longint off);
        if (off < 0 || off >= 512) begin
            oor = 1'b1;
            return 0;
        end
        if (int'(off) > maxoff) maxoff = int'(off);
        return int'(img[int'(off)]);
    endfunction

    task automatic model(output bit e, output logic [31:0] st, output logic [31:0] by, output int cons);
        int h, n, id, cnt;
        longint base, sum, v, bp;
        logic [31:0] o, ps, as;
        bit gp, ga, found;
        maxoff = -1; oor = 1'b0; e = 1'b0; st = '0; by = '0;
        gp = 0; ga = 0; found = 0; ps = '0; as = '0; sum = 0;
        h = rdm(24);
        if (h == 0) begin e = 1; cons = maxoff + 1; return; end
        n = rdm(h - 1);
        for (int r = 0; r < n; r++) begin
            base = longint'(h) + 9 * r;
            id = rdm(base);
            o = '0;
            for (int b = 0; b < 4; b++) o[8*b +: 8] = 8'(rdm(base + 1 + b));
            if (id == 8) begin ps = o; gp = (o != 0); end
            if (id == 5) begin as = o; ga = (o != 0); end
            if (gp && ga) begin found = 1; break; end
        end
        if (!found || oor) begin e = 1; cons = maxoff + 1; return; end
        cnt = rdm(55) | (rdm(56) << 8);
        for (int i = 0; i < cnt; i++) begin
            v = 0;
            for (int b = 0; b < 22; b++) begin
                bp = longint'(i) * 22 + b;
                v = v | (longint'((rdm(longint'(as) + bp / 8) >> (bp % 8)) & 1) << b);
                if (oor) break;
            end
            if (oor) begin e = 1; cons = maxoff + 1; return; end
            sum = sum + v * 16;
            if (sum > 64'hFFFF_FFFF) begin e = 1; cons = maxoff + 1; return; end
        end
        st = ps; by = sum[31:0]; cons = maxoff + 1;
    endtask

    // ---------------- image construction ----------------
    task automatic put_rec(int h, int r, int id, logic [31:0] off);
        img[h + 9*r] = 8'(id);
        for (int b = 0; b < 4; b++) img[h + 9*r + 1 + b] = off[8*b +: 8];
    endtask

    task automatic put_size(int arr, int i, logic [21:0] val);
        for (int b = 0; b < 22; b++) begin
            int p;
            p = i * 22 + b;
            img[arr + p/8][p%8] = val[b];
        end
    endtask

    task automatic put_cnt(int cnt);
        img[55] = 8'(cnt);
        img[56] = 8'(cnt >> 8);
    endtask

    task automatic build_random(output int h, output int n, output int arr,
                                output int s8, output int s5, input int cnt);
        for (int i = 0; i < 2048; i++) img[i] = 8'($urandom);
        h = 60 + int'($urandom % 21);
        n = 2 + int'($urandom % 4);
        img[24] = 8'(h);
        img[h - 1] = 8'(n);
        s8 = int'($urandom % n);
        s5 = (s8 + 1 + int'($urandom % (n - 1))) % n;
        arr = h + 9 * n + int'($urandom % 8);
        for (int r = 0; r < n; r++) begin
            int fid;
            fid = (r == s8) ? 8 : (r == s5) ? 5 : (1 + int'($urandom % 4));
            put_rec(h, r, fid, (r == s5) ? 32'(arr) : ($urandom | 32'd1));
        end
        put_cnt(cnt);
        for (int i = 0; i < cnt; i++) put_size(arr, i, 22'($urandom));
    endtask

    // ---------------- stimulus and check of one image ----------------
    task automatic run_image(string req, string tag);
        bit e, took, seen;
        logic [31:0] st, by;
        int cons, idx;
        model(e, st, by, cons);
        idx = 0; took = 0; seen = 0;
        for (int w = 0; w < 6000; w++) begin
            @(negedge clk);
            if (took) idx++;
            if (done) begin seen = 1; break; end
            in_valid = ($urandom % 4) != 0;
            in_data  = img[idx];
            took     = in_valid && in_ready;
        end
        in_valid = 1'b0;
        chk(seen, "R11", {tag, " done strobe"}, longint'(seen), 1);
        if (seen) begin
            chk(err == e, req, {tag, " err"}, longint'(err), longint'(e));
            chk(idx == cons, "R10", {tag, " bytes consumed"}, idx, cons);
            chk(in_ready == 1'b1, "R12", {tag, " ready for next image"}, longint'(in_ready), 1);
            if (!e) begin
                chk(pay_start == st, "R7", {tag, " pay_start"}, pay_start, st);
                chk(pay_bytes == by, req, {tag, " pay_bytes"}, pay_bytes, by);
            end else begin
                chk(pay_bytes == 0 && pay_start == 0, "R11", {tag, " zeroed on err"}, pay_bytes, 0);
            end
        end
    endtask

    initial begin
        #(1_900_000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int h, n, arr, s8, s5;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk(done == 0 && err == 0, "R12", "reset flags", longint'(done | err), 0);
        chk(pay_start == 0 && pay_bytes == 0, "R12", "reset results", pay_bytes, 0);
        chk(in_ready == 1, "R12", "reset ready", longint'(in_ready), 1);

        // R6/R7: random well-formed images
        for (int t = 0; t < 25; t++) begin
            build_random(h, n, arr, s8, s5, 1 + int'($urandom % 30));
            run_image("R6", "random image");
        end

        // R6: alternating patterns expose neighbour leakage across byte edges
        build_random(h, n, arr, s8, s5, 4);
        put_size(arr, 0, 22'h3FFFFF); put_size(arr, 1, 22'h000000);
        put_size(arr, 2, 22'h2AAAAA); put_size(arr, 3, 22'h155555);
        run_image("R6", "pattern sizes");

        // R1: zero header length
        build_random(h, n, arr, s8, s5, 3);
        img[24] = 8'd0;
        run_image("R1", "zero header length");

        // R4: zero record count
        build_random(h, n, arr, s8, s5, 3);
        img[h - 1] = 8'd0;
        run_image("R4", "zero records");

        // R4: size-array record missing
        build_random(h, n, arr, s8, s5, 3);
        img[h + 9*s5] = 8'd3;
        run_image("R4", "missing id 5");

        // R4: payload record holds zero offset
        build_random(h, n, arr, s8, s5, 3);
        put_rec(h, s8, 8, 32'd0);
        run_image("R4", "zero payload offset");

        // R2/R3: duplicate identifier, early stop, array placed before table
        for (int i = 0; i < 2048; i++) img[i] = 8'($urandom);
        img[24] = 8'd64; img[63] = 8'd4;
        put_rec(64, 0, 8, 32'h1111_0001);
        put_rec(64, 1, 8, 32'hABCD_1234);
        put_rec(64, 2, 5, 32'd30);
        put_rec(64, 3, 8, 32'h0000_0777);
        put_cnt(3);
        put_size(30, 0, 22'd5); put_size(30, 1, 22'd100); put_size(30, 2, 22'h3FFFFF);
        run_image("R3", "override and early stop");

        // R5: zero components
        build_random(h, n, arr, s8, s5, 0);
        run_image("R5", "zero components");

        // R8: largest total that fits, then one that overflows
        build_random(h, n, arr, s8, s5, 64);
        for (int i = 0; i < 64; i++) put_size(arr, i, 22'h3FFFFF);
        run_image("R8", "64 max sizes");
        build_random(h, n, arr, s8, s5, 70);
        for (int i = 0; i < 70; i++) put_size(arr, i, 22'h3FFFFF);
        run_image("R8", "70 max sizes overflow");

        // R9: size array beyond the buffer
        build_random(h, n, arr, s8, s5, 2);
        put_rec(h, s5, 5, 32'd600);
        run_image("R9", "array out of range");

        // R9: payload offset itself may be large without harm
        build_random(h, n, arr, s8, s5, 2);
        put_rec(h, s8, 8, 32'hFFFF_FFF0);
        run_image("R7", "large payload offset");

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule